// File: doc/BRIEF.md
# Four-Stage Nibble Processor Core

A minimal in-order processor with a 4-bit datapath and a four-stage pipeline: fetch, decode, execute and writeback. The fetch stage presents a 4-bit program counter to a synchronous instruction ROM, and the ROM returns the instruction one clock later. The decode stage splits the instruction into fields, reads two source registers and checks the zero flag. The execute stage runs the ALU. The writeback stage updates the destination register and, for arithmetic instructions, the zero flag.

The instruction set has four operations: add, nand, load immediate, and branch when the zero flag is set. There are four registers. Register 0 always reads as zero. Register 1 is driven onto an output port at all times.

The pipeline has no forwarding and no interlocks, so software must keep dependent instructions apart. The register file and the zero flag are write-through: an instruction in decode sees a value that is being written back in the same cycle. As a result, one intervening instruction between a producer and its consumer is enough. A branch is resolved in decode. The instruction fetched during that cycle always executes as a delay slot.

Top module: `nib4_core`

## Requirements
- R1: Opcode 00 in bits [7:6] is add: rd[5:4] receives (rs[3:2] + rt[1:0]) modulo 16.
- R2: Opcode 01 is nand: rd receives the bitwise inverse of (rs AND rt).
- R3: Opcode 10 is load immediate: rd receives bits [3:0] of the instruction.
- R4: Register 0 always reads as zero, and a write to it has no effect.
- R5: `r1_out` shows register 1. An instruction whose ROM address is sampled at clock edge k changes `r1_out` right after edge k+3.
- R6: An instruction that reads a register two slots after the instruction producing it sees the new value. An instruction that reads it in the very next slot sees the old value.
- R7: The zero flag is written only by add and nand, at writeback, and is set exactly when their 4-bit result is zero. Load immediate leaves it unchanged. Decode sees a flag value written in the same cycle.
- R8: Opcode 11 is branch-if-zero with an absolute target in bits [3:0]. When the flag is set, fetch continues at the target. The next sequential instruction (the delay slot) still executes, and the one after it does not.
- R9: A branch whose flag is clear does not redirect fetch, and execution continues in sequence.
- R10: Reset (`rst_n` low) clears the program counter, all registers, the zero flag and the pipeline, so `rom_addr` and `r1_out` read 0. After release, no stale instruction writes anything.
- R11: The program counter advances by one per cycle when no branch is taken and wraps from 15 to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| rom_addr | output | 4 | Program counter presented to the instruction ROM |
| rom_data | input | 8 | Instruction returned by the ROM one cycle after the address |
| r1_out | output | 4 | Current contents of register 1 |

## Verification
The hardest situations to reach from the ports are the same-cycle write-through cases. In these, a branch in decode must see a zero flag that is only being written back in that cycle, or an operand must see a register that is being written in that cycle. The stimulus reaches them with short ROM programs in which the producer sits exactly two slots ahead of the consumer. Other programs place the consumer one slot ahead instead, to show the stale value. Every effect is made visible by copying the result into register 1 or by choosing which of two writes to register 1 a taken or untaken branch lets through.

// File: rtl/nc_pkg.sv
package nc_pkg;
  localparam int DW   = 4;
  localparam int AW   = 4;
  localparam int RIW  = 2;
  localparam int NREG = 1 << RIW;
  localparam int OPW  = 2;
  localparam int IW   = OPW + 3 * RIW;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 2'd0,
    OP_NAND = 2'd1,
    OP_LDI  = 2'd2,
    OP_BZ   = 2'd3
  } op_e;

  typedef struct packed {
    logic            valid;
    op_e             op;
    logic [RIW-1:0]  rd;
    logic [DW-1:0]   a;
    logic [DW-1:0]   b;
    logic [DW-1:0]   imm;
  } ex_t;

  typedef struct packed {
    logic            we;
    logic            zf_we;
    logic [RIW-1:0]  rd;
    logic [DW-1:0]   res;
  } wb_t;

  function automatic logic [DW-1:0] f_alu(op_e op, logic [DW-1:0] a,
                                          logic [DW-1:0] b, logic [DW-1:0] imm);
    case (op)
      OP_ADD:  return a + b;
      OP_NAND: return ~(a & b);
      OP_LDI:  return imm;
      default: return '0;
    endcase
  endfunction

  function automatic logic f_sets_flag(op_e op);
    return (op == OP_ADD) || (op == OP_NAND);
  endfunction
endpackage

// File: rtl/nc_fetch.sv
module nc_fetch import nc_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          redirect,
  input  logic [AW-1:0] target,
  output logic [AW-1:0] pc_o,
  output logic          dec_valid_o
);
  localparam logic [AW-1:0] PC_ONE = 1;

  logic [AW-1:0] pc_q;
  logic          valid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      valid_q <= 1'b0;
    end else begin
      pc_q    <= redirect ? target : pc_q + PC_ONE;
      valid_q <= 1'b1;
    end
  end

  assign pc_o        = pc_q;
  assign dec_valid_o = valid_q;

  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(redirect)) |-> pc_q == $past(pc_q) + PC_ONE); // R11
  AST_PC_JUMP: assert property (@(posedge clk) disable iff (!rst_n)
    redirect |=> pc_q == $past(target)); // R8
endmodule

// File: rtl/nc_regfile.sv
module nc_regfile import nc_pkg::*; (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [RIW-1:0] wa,
  input  logic [DW-1:0]  wd,
  input  logic [RIW-1:0] ra1,
  input  logic [RIW-1:0] ra2,
  output logic [DW-1:0]  rd1,
  output logic [DW-1:0]  rd2,
  output logic [DW-1:0]  r1_o
);
  logic [DW-1:0] regs_q [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else begin
      for (int i = 1; i < NREG; i++)
        if (we && wa == RIW'(i)) regs_q[i] <= wd;
    end
  end

  function automatic logic [DW-1:0] f_read(logic [RIW-1:0] addr);
    if (addr == '0)             return '0;
    else if (we && wa == addr)  return wd;
    else                        return regs_q[addr];
  endfunction

  assign rd1  = f_read(ra1);
  assign rd2  = f_read(ra2);
  assign r1_o = regs_q[1];

  AST_R1_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(we && wa == RIW'(1))) |-> r1_o == $past(wd)); // R5
endmodule

// File: rtl/nc_execute.sv
module nc_execute import nc_pkg::*; (
  input  logic clk,
  input  logic rst_n,
  input  ex_t  ex_d,
  output wb_t  wb_o
);
  ex_t ex_q;
  wb_t wb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ex_q <= '0;
      wb_q <= '0;
    end else begin
      ex_q        <= ex_d;
      wb_q.we     <= ex_q.valid;
      wb_q.zf_we  <= ex_q.valid && f_sets_flag(ex_q.op);
      wb_q.rd     <= ex_q.rd;
      wb_q.res    <= f_alu(ex_q.op, ex_q.a, ex_q.b, ex_q.imm);
    end
  end

  assign wb_o = wb_q;

  AST_BUBBLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(ex_q.valid)) |-> !wb_q.we); // R10
endmodule

// File: rtl/nib4_core.sv
module nib4_core import nc_pkg::*; (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] rom_addr,
  input  logic [IW-1:0] rom_data,
  output logic [DW-1:0] r1_out
);
  // fetch
  logic          dec_valid;
  logic          br_taken;
  logic [AW-1:0] br_target;

  nc_fetch u_fetch (
    .clk(clk), .rst_n(rst_n), .redirect(br_taken), .target(br_target),
    .pc_o(rom_addr), .dec_valid_o(dec_valid)
  );

  // decode fields
  op_e            dec_op;
  logic [RIW-1:0] dec_rd, dec_rs, dec_rt;
  logic [DW-1:0]  dec_a, dec_b;
  logic           dec_is_branch;

  assign dec_op        = op_e'(rom_data[IW-1 -: OPW]);
  assign dec_rd        = rom_data[IW-OPW-1 -: RIW];
  assign dec_rs        = rom_data[IW-OPW-RIW-1 -: RIW];
  assign dec_rt        = rom_data[RIW-1:0];
  assign br_target     = rom_data[AW-1:0];
  assign dec_is_branch = dec_valid && (dec_op == OP_BZ);

  // writeback path
  wb_t  wb;
  logic wb_write;
  logic zf_q;
  logic zf_now;

  assign wb_write = wb.we;

  nc_regfile u_rf (
    .clk(clk), .rst_n(rst_n), .we(wb_write), .wa(wb.rd), .wd(wb.res),
    .ra1(dec_rs), .ra2(dec_rt), .rd1(dec_a), .rd2(dec_b), .r1_o(r1_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         zf_q <= 1'b0;
    else if (wb.zf_we)  zf_q <= (wb.res == '0);
  end

  assign zf_now   = wb.zf_we ? (wb.res == '0) : zf_q;
  assign br_taken = dec_is_branch && zf_now;

  ex_t ex_d;
  always_comb begin
    ex_d.valid = dec_valid && (dec_op != OP_BZ);
    ex_d.op    = dec_op;
    ex_d.rd    = dec_rd;
    ex_d.a     = dec_a;
    ex_d.b     = dec_b;
    ex_d.imm   = rom_data[DW-1:0];
  end

  nc_execute u_ex (.clk(clk), .rst_n(rst_n), .ex_d(ex_d), .wb_o(wb));

  AST_ZF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(wb.zf_we)) |-> $stable(zf_q)); // R7
  AST_TAKEN_IS_BZ: assert property (@(posedge clk) disable iff (!rst_n)
    br_taken |-> (rom_data[IW-1 -: OPW] == 2'b11) && dec_valid); // R8
endmodule

// File: tb/test_nib4_core.sv
`timescale 1ns/1ps
module test_nib4_core;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] rom_addr;
  logic [7:0] rom_data;
  logic [3:0] r1_out;
  logic [7:0] rom [16];

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  nib4_core i_nib4_core (
    .clk(clk), .rst_n(rst_n), .rom_addr(rom_addr), .rom_data(rom_data), .r1_out(r1_out)
  );

  always_ff @(posedge clk) rom_data <= rom[rom_addr];

  // entry: {req[3:0], expected r1[3:0], program addr0..addr15 left to right}
  localparam int NV = 12;
  localparam logic [135:0] VECS [NV] = '{
    {4'd3,  4'h9, 128'h99808080_80808080_80808080_80808080},  // R3 ldi r1,9
    {4'd1,  4'h3, 128'hA7BC801B_80808080_80808080_80808080},  // R1 7+12 wraps to 3
    {4'd10, 4'h0, 128'h95801B80_80808080_80808080_80808080},  // R10 r2,r3 cleared by reset
    {4'd2,  4'hD, 128'hAAB6805B_80808080_80808080_80808080},  // R2 nand A,6 = D
    {4'd4,  4'h0, 128'h9F858010_80808080_80808080_80808080},  // R4 ldi r0 ignored
    {4'd6,  4'h0, 128'h93A41A80_80808080_80808080_80808080},  // R6 next slot reads stale r2
    {4'd6,  4'h8, 128'hA4801A80_80808080_80808080_80808080},  // R6 two slots later sees r2
    {4'd8,  4'h2, 128'h0080C691_92938015_80808080_80808080},  // R8 taken, delay slot runs
    {4'd9,  4'h6, 128'h00A1803A_80C99596_80808080_80808080},  // R9 flag cleared, not taken
    {4'd7,  4'h2, 128'h00A38092_C8809780_80808080_80808080},  // R7 ldi keeps flag set
    {4'd7,  4'h4, 128'hAF807A80_C8949780_80808080_80808080},  // R7 nand zero sets flag
    {4'd10, 4'h9, 128'h80C58099_80808080_80808080_80808080}   // R10 flag cleared by reset
  };

  task automatic check(input int req, input logic [7:0] act, input logic [7:0] exp,
                       input string what);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic reset_with(input logic [127:0] prog);
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 16; i++) rom[i] = prog[127 - 8*i -: 8];
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog (all requirements) actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    for (int i = 0; i < 16; i++) rom[i] = 8'h80;
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(10, {4'h0, r1_out}, 8'h0, "reset r1_out");      // R10
    check(10, {4'h0, rom_addr}, 8'h0, "reset rom_addr");  // R10

    // R5 latency: ldi r1,B at address 0
    reset_with(128'h9B808080_80808080_80808080_80808080);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(5, {4'h0, r1_out}, 8'h0, "r1 before edge k+3");
    check(11, {4'h0, rom_addr}, 8'h3, "pc after three edges");  // R11
    @(posedge clk);
    @(negedge clk);
    check(5, {4'h0, r1_out}, 8'hB, "r1 after edge k+3");

    // R11 wrap
    reset_with({16{8'h80}});
    repeat (15) @(posedge clk);
    @(negedge clk);
    check(11, {4'h0, rom_addr}, 8'hF, "pc at 15");
    @(posedge clk);
    @(negedge clk);
    check(11, {4'h0, rom_addr}, 8'h0, "pc wraps to 0");

    for (int v = 0; v < NV; v++) begin
      reset_with(VECS[v][127:0]);
      repeat (12) @(posedge clk);
      @(negedge clk);
      check(int'(VECS[v][135:132]), {4'h0, r1_out}, {4'h0, VECS[v][131:128]},
            $sformatf("program %0d r1", v));
    end

    // R10 reset in the middle of activity
    @(negedge clk);
    rst_n = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check(10, {4'h0, r1_out}, 8'h0, "r1 cleared by reset");
    check(10, {4'h0, rom_addr}, 8'h0, "pc cleared by reset");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule